// File: doc/BRIEF.md
# Host-Bus Interrupt Controller

This block sits between an external host processor bus and an on-chip slave CPU and handles the interrupt signalling of a two-channel mailbox. In the slave direction, a host write to a channel's inbound data register marks that channel full. A per-channel enable then turns the full flag into a level interrupt to the slave. The slave acknowledges the interrupt by reading the inbound register.

In the host direction, three request latches sit in bits 5:3 of a slave-visible port register and drive three host interrupt lines. The slave arms a latch by reading the register while the bit is 0, and a later write of 1 then sets it. A write of 0 clears the latch. The host clears a latch by reading the outbound data register of a particular channel. Host strobes are asynchronous to the block clock. They pass through a synchronizer, and only the falling edge of the read or write strobe counts.

Top module: `hostirq_ctrl`

## Requirements
- R1: After reset all full flags, enables, arm flags and request latches are 0, and both interrupt outputs are all-zero.
- R2: A host write strobe falling edge with chip select n low and `hst_a0_i` low sets full flag n. A slave read of address 2 clears full flag 1, and a read of address 3 clears full flag 2. If a host write and a slave read of the same channel meet, the set wins.
- R3: `rx_irq_o[n]` is high exactly while full flag n is set and enable bit n of the control register (address 1, bits 1:0) is 1. The full flags read back at address 1, bits 3:2.
- R4: A slave read of address 0 arms each latch bit (port bits 3,4,5 map to `host_irq_o[0]`,`[1]`,`[2]`) that reads as 0. A write of 1 to a bit sets its latch only if that bit is armed, and otherwise leaves it unchanged.
- R5: Any slave write to address 0 disarms all three bits, so a second write of 1 without a fresh read does not set a latch.
- R6: A slave write of 0 to a latch bit clears that latch.
- R7: A host read of channel 2 (chip select 2 low, `hst_a0_i` low) clears `host_irq_o[0]`. A host read of channel 1 clears `host_irq_o[1]` and `host_irq_o[2]`.
- R8: Each falling edge of the host read strobe clears the latches once. A latch set while the strobe stays low stays set.
- R9: A host read with `hst_a0_i` high, or with no chip select low, clears no latch.
- R10: When a host-read clear and a slave set of the same latch fall in the same cycle, the latch ends up cleared.
- R11: While `slave_mode_i` is low, `host_irq_o` is all-zero and writes of 1 do not set latches.
- R12: A slave register access takes effect at the next clock edge. A host strobe edge takes effect SYNC_STAGES+1 clock edges after it is first sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slave_mode_i | input | 1 | Enables the host request latches |
| sl_sel_i | input | 1 | Slave register access strobe, one cycle |
| sl_wr_i | input | 1 | 1 = write, 0 = read |
| sl_addr_i | input | 2 | 0 port, 1 control/status, 2 inbound 1, 3 inbound 2 |
| sl_wdata_i | input | 8 | Slave write data |
| sl_rdata_o | output | 8 | Slave read data, combinational |
| hst_cs_n_i | input | 2 | Host chip selects, channel 1 in bit 0 |
| hst_a0_i | input | 1 | Host address bit, 0 selects the data register |
| hst_rd_n_i | input | 1 | Host read strobe, active low |
| hst_wr_n_i | input | 1 | Host write strobe, active low |
| rx_irq_o | output | 2 | Inbound-full interrupts to the slave |
| host_irq_o | output | 3 | Host interrupt requests |

## Verification
Slave accesses are due one edge after the access cycle, so the bench drives on a falling edge and samples on the next falling edge. Host strobe effects are due SYNC_STAGES+1 rising edges after the strobe is driven. Each host operation holds the strobe for that many edges before it samples, and then lets the release settle for the same count. The latency requirement is probed one edge early and again on time. The clear-versus-set race is timed so that the slave write lands in the exact cycle the synchronized edge pulse is live.

// File: rtl/hostirq_pkg.sv
package hostirq_pkg;

  localparam int NUM_CH    = 2;
  localparam int NUM_HREQ  = 3;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 2;
  localparam int HREQ_LSB  = 3;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_PORT = 2'd0,
    ADDR_CTRL = 2'd1,
    ADDR_IN1  = 2'd2,
    ADDR_IN2  = 2'd3
  } sl_addr_e;

  // Which host-side read clears which request latch:
  // channel 2 read clears latch 0; channel 1 read clears latches 1 and 2.
  function automatic logic [NUM_HREQ-1:0] hreq_clear_map(input logic [NUM_CH-1:0] rd_hit);
    return {rd_hit[0], rd_hit[0], rd_hit[1]};
  endfunction

endpackage

// File: rtl/hostirq_sync.sv
module hostirq_sync
  import hostirq_pkg::*;
#(
  parameter int STAGES = 2,
  parameter int CH     = NUM_CH
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CH-1:0] cs_n_i,
  input  logic          a0_i,
  input  logic          rd_n_i,
  input  logic          wr_n_i,
  output logic [CH-1:0] rd_hit_o,
  output logic [CH-1:0] wr_hit_o
);

  localparam int W = CH + 3;

  logic [W-1:0] pipe_q [STAGES];
  logic [W-1:0] pipe_d [STAGES];
  logic [1:0]   prev_q;
  logic [1:0]   prev_d;
  logic [W-1:0] samp;
  logic [CH-1:0] s_cs_n;
  logic          s_a0, s_rd_n, s_wr_n;
  logic          rd_fall, wr_fall;

  always_comb begin
    pipe_d[0] = {cs_n_i, a0_i, rd_n_i, wr_n_i};
    for (int s = 1; s < STAGES; s++) pipe_d[s] = pipe_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) pipe_q[s] <= '1;
    end else begin
      for (int s = 0; s < STAGES; s++) pipe_q[s] <= pipe_d[s];
    end
  end

  assign samp = pipe_q[STAGES-1];
  assign {s_cs_n, s_a0, s_rd_n, s_wr_n} = samp;

  assign prev_d = {s_rd_n, s_wr_n};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 2'b11;
    else        prev_q <= prev_d;
  end

  assign rd_fall = prev_q[1] & ~s_rd_n;
  assign wr_fall = prev_q[0] & ~s_wr_n;

  for (genvar c = 0; c < CH; c++) begin : g_hit
    assign rd_hit_o[c] = rd_fall & ~s_cs_n[c] & ~s_a0;
    assign wr_hit_o[c] = wr_fall & ~s_cs_n[c] & ~s_a0;
  end

  // R8: a held-low read strobe yields one pulse only
  p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fall |=> !rd_fall);

endmodule

// File: rtl/hostirq_rxflags.sv
module hostirq_rxflags
  import hostirq_pkg::*;
#(
  parameter int CH = NUM_CH
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CH-1:0] wr_hit_i,
  input  logic [CH-1:0] rd_clr_i,
  input  logic          en_we_i,
  input  logic [CH-1:0] en_wdata_i,
  output logic [CH-1:0] full_o,
  output logic [CH-1:0] en_o,
  output logic [CH-1:0] irq_o
);

  logic [CH-1:0] full_q, full_d;
  logic [CH-1:0] en_q, en_d;
  logic          full_ce;

  always_comb begin
    full_ce = |{wr_hit_i, rd_clr_i};
    full_d  = (full_q & ~rd_clr_i) | wr_hit_i;
    en_d    = en_wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= '0;
      en_q   <= '0;
    end else begin
      if (full_ce) full_q <= full_d;
      if (en_we_i) en_q   <= en_d;
    end
  end

  assign full_o = full_q;
  assign en_o   = en_q;
  assign irq_o  = full_q & en_q;

  for (genvar c = 0; c < CH; c++) begin : g_chk
    // R2: host write always lands
    p_host_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit_i[c] |=> full_q[c]);
    // R2: slave read clears when no concurrent host write
    p_slave_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr_i[c] && !wr_hit_i[c]) |=> !full_q[c]);
  end

endmodule

// File: rtl/hostirq_latch.sv
module hostirq_latch
  import hostirq_pkg::*;
#(
  parameter int NR = NUM_HREQ
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_i,
  input  logic          port_rd_i,
  input  logic          port_wr_i,
  input  logic [NR-1:0] wdata_i,
  input  logic [NR-1:0] host_clr_i,
  output logic [NR-1:0] latch_o
);

  logic [NR-1:0] latch_q, latch_d;
  logic [NR-1:0] arm_q, arm_d;
  logic          ce;

  always_comb begin
    ce      = port_rd_i | port_wr_i | (|host_clr_i);
    latch_d = latch_q;
    arm_d   = arm_q;
    for (int i = 0; i < NR; i++) begin
      if (port_rd_i) arm_d[i] = ~latch_q[i];
      if (port_wr_i) begin
        arm_d[i] = 1'b0;
        if (!wdata_i[i])                latch_d[i] = 1'b0;
        else if (arm_q[i] && mode_i)    latch_d[i] = 1'b1;
      end
      if (host_clr_i[i]) latch_d[i] = 1'b0;   // clear has priority
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      arm_q   <= '0;
    end else if (ce) begin
      latch_q <= latch_d;
      arm_q   <= arm_d;
    end
  end

  assign latch_o = latch_q;

  for (genvar i = 0; i < NR; i++) begin : g_chk
    // R4: an unarmed clear latch cannot become set
    p_unarmed_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!latch_q[i] && !arm_q[i]) |=> !latch_q[i]);
    // R6: write of zero clears
    p_wr0_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (port_wr_i && !wdata_i[i]) |=> !latch_q[i]);
    // R10: host clear beats any same-cycle set
    p_clear_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      host_clr_i[i] |=> !latch_q[i]);
  end

endmodule

// File: rtl/hostirq_ctrl.sv
module hostirq_ctrl
  import hostirq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                slave_mode_i,
  input  logic                sl_sel_i,
  input  logic                sl_wr_i,
  input  logic [ADDR_W-1:0]   sl_addr_i,
  input  logic [DATA_W-1:0]   sl_wdata_i,
  output logic [DATA_W-1:0]   sl_rdata_o,
  input  logic [NUM_CH-1:0]   hst_cs_n_i,
  input  logic                hst_a0_i,
  input  logic                hst_rd_n_i,
  input  logic                hst_wr_n_i,
  output logic [NUM_CH-1:0]   rx_irq_o,
  output logic [NUM_HREQ-1:0] host_irq_o
);

  logic [1:0]          rst_pipe_q;
  logic                rst_sync_n;
  logic [NUM_CH-1:0]   rd_hit, wr_hit;
  logic [NUM_CH-1:0]   full, en, rd_clr;
  logic [NUM_HREQ-1:0] latch, host_clr;
  logic                sl_rd, sl_wr;
  logic                port_rd, port_wr, ctrl_wr;
  logic                unused_wbits;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  always_comb begin
    sl_rd     = sl_sel_i & ~sl_wr_i;
    sl_wr     = sl_sel_i &  sl_wr_i;
    port_rd   = sl_rd & (sl_addr_i == ADDR_PORT);
    port_wr   = sl_wr & (sl_addr_i == ADDR_PORT);
    ctrl_wr   = sl_wr & (sl_addr_i == ADDR_CTRL);
    rd_clr[0] = sl_rd & (sl_addr_i == ADDR_IN1);
    rd_clr[1] = sl_rd & (sl_addr_i == ADDR_IN2);
  end

  assign unused_wbits = ^{sl_wdata_i[DATA_W-1:HREQ_LSB+NUM_HREQ],
                          sl_wdata_i[HREQ_LSB-1:NUM_CH]};

  hostirq_sync #(.STAGES(SYNC_STAGES), .CH(NUM_CH)) u_sync (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .cs_n_i   (hst_cs_n_i),
    .a0_i     (hst_a0_i),
    .rd_n_i   (hst_rd_n_i),
    .wr_n_i   (hst_wr_n_i),
    .rd_hit_o (rd_hit),
    .wr_hit_o (wr_hit)
  );

  hostirq_rxflags #(.CH(NUM_CH)) u_rx (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_hit_i   (wr_hit),
    .rd_clr_i   (rd_clr),
    .en_we_i    (ctrl_wr),
    .en_wdata_i (sl_wdata_i[NUM_CH-1:0]),
    .full_o     (full),
    .en_o       (en),
    .irq_o      (rx_irq_o)
  );

  assign host_clr = hreq_clear_map(rd_hit);

  hostirq_latch #(.NR(NUM_HREQ)) u_latch (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .mode_i     (slave_mode_i),
    .port_rd_i  (port_rd),
    .port_wr_i  (port_wr),
    .wdata_i    (sl_wdata_i[HREQ_LSB +: NUM_HREQ]),
    .host_clr_i (host_clr),
    .latch_o    (latch)
  );

  assign host_irq_o = latch & {NUM_HREQ{slave_mode_i}};

  always_comb begin
    sl_rdata_o = '0;
    unique case (sl_addr_i)
      ADDR_PORT: sl_rdata_o[HREQ_LSB +: NUM_HREQ] = latch;
      ADDR_CTRL: sl_rdata_o[2*NUM_CH-1:0]         = {full, en};
      ADDR_IN1:  sl_rdata_o[0]                    = full[0];
      ADDR_IN2:  sl_rdata_o[0]                    = full[1];
      default:   sl_rdata_o                       = '0;
    endcase
  end

  for (genvar i = 0; i < NUM_HREQ; i++) begin : g_mode_chk
    // R11: with slave mode off a clear latch stays clear
    p_mode_off_hold_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (!slave_mode_i && !latch[i]) |=> !latch[i]);
  end

endmodule

// File: tb/hostirq_ctrl_bench.sv
module hostirq_ctrl_bench;

  localparam int CLK_PERIOD  = 10;
  localparam int SYNC_STAGES = 2;
  localparam int HOST_LAT    = SYNC_STAGES + 1;
  localparam logic [1:0] OP_SWR = 2'd0, OP_SRD = 2'd1, OP_HRD = 2'd2, OP_HWR = 2'd3;

  logic       clk = 1'b0;
  logic       rst_n, slave_mode;
  logic       sl_sel, sl_wr;
  logic [1:0] sl_addr;
  logic [7:0] sl_wdata, sl_rdata;
  logic [1:0] hst_cs_n;
  logic       hst_a0, hst_rd_n, hst_wr_n;
  logic [1:0] rx_irq;
  logic [2:0] host_irq;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hostirq_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_hostirq_ctrl (
    .clk(clk), .rst_n(rst_n), .slave_mode_i(slave_mode),
    .sl_sel_i(sl_sel), .sl_wr_i(sl_wr), .sl_addr_i(sl_addr),
    .sl_wdata_i(sl_wdata), .sl_rdata_o(sl_rdata),
    .hst_cs_n_i(hst_cs_n), .hst_a0_i(hst_a0), .hst_rd_n_i(hst_rd_n),
    .hst_wr_n_i(hst_wr_n), .rx_irq_o(rx_irq), .host_irq_o(host_irq));

  // {op, addr/ch, data, a0, exp host_irq, exp rx_irq, requirement}
  function automatic logic [21:0] v(input logic [1:0] op, input logic [1:0] a,
                                    input logic [7:0] d, input logic a0,
                                    input logic [2:0] eh, input logic [1:0] er,
                                    input logic [3:0] rq);
    return {op, a, d, a0, eh, er, rq};
  endfunction

  localparam logic [21:0] VEC [21] = '{
    v(OP_SWR, 2'd1, 8'h03, 1'b0, 3'b000, 2'b00, 4'd3),  // R3 enable both
    v(OP_HWR, 2'd1, 8'h00, 1'b0, 3'b000, 2'b01, 4'd2),  // R2 host write ch1
    v(OP_HWR, 2'd2, 8'h00, 1'b0, 3'b000, 2'b11, 4'd2),  // R2 host write ch2
    v(OP_SRD, 2'd2, 8'h00, 1'b0, 3'b000, 2'b10, 4'd2),  // R2 slave read clears ch1
    v(OP_SWR, 2'd1, 8'h01, 1'b0, 3'b000, 2'b00, 4'd3),  // R3 mask ch2
    v(OP_SWR, 2'd1, 8'h03, 1'b0, 3'b000, 2'b10, 4'd3),  // R3 unmask ch2
    v(OP_SRD, 2'd3, 8'h00, 1'b0, 3'b000, 2'b00, 4'd2),  // R2 slave read clears ch2
    v(OP_SWR, 2'd0, 8'h38, 1'b0, 3'b000, 2'b00, 4'd4),  // R4 unarmed write
    v(OP_SRD, 2'd0, 8'h00, 1'b0, 3'b000, 2'b00, 4'd4),  // R4 arm
    v(OP_SWR, 2'd0, 8'h38, 1'b0, 3'b111, 2'b00, 4'd4),  // R4 set all
    v(OP_SWR, 2'd0, 8'h10, 1'b0, 3'b010, 2'b00, 4'd6),  // R6 clear bits 3,5
    v(OP_SRD, 2'd0, 8'h00, 1'b0, 3'b010, 2'b00, 4'd4),  // R4 arm 3,5
    v(OP_SWR, 2'd0, 8'h38, 1'b0, 3'b111, 2'b00, 4'd4),  // R4 set again
    v(OP_HRD, 2'd2, 8'h00, 1'b0, 3'b110, 2'b00, 4'd7),  // R7 ch2 read
    v(OP_HRD, 2'd1, 8'h00, 1'b0, 3'b000, 2'b00, 4'd7),  // R7 ch1 read
    v(OP_SWR, 2'd0, 8'h38, 1'b0, 3'b000, 2'b00, 4'd5),  // R5 arm consumed
    v(OP_SRD, 2'd0, 8'h00, 1'b0, 3'b000, 2'b00, 4'd4),
    v(OP_SWR, 2'd0, 8'h38, 1'b0, 3'b111, 2'b00, 4'd4),
    v(OP_HRD, 2'd1, 8'h00, 1'b1, 3'b111, 2'b00, 4'd9),  // R9 a0 high
    v(OP_HRD, 2'd0, 8'h00, 1'b0, 3'b111, 2'b00, 4'd9),  // R9 no select
    v(OP_SWR, 2'd0, 8'h00, 1'b0, 3'b000, 2'b00, 4'd6)   // R6 clear all
  };

  task automatic check(input int rq, input string what, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL R%0d %s: actual=%h expected=%h", rq, what, got, exp);
    end
  endtask

  task automatic slave_op(input logic wr, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    sl_sel = 1'b1; sl_wr = wr; sl_addr = a; sl_wdata = d;
    @(posedge clk);
    @(negedge clk);
    sl_sel = 1'b0; sl_wr = 1'b0;
  endtask

  task automatic host_drive(input logic rd, input logic [1:0] ch, input logic a0);
    @(negedge clk);
    hst_cs_n = (ch == 2'd1) ? 2'b10 : (ch == 2'd2) ? 2'b01 : 2'b11;
    hst_a0 = a0;
    if (rd) hst_rd_n = 1'b0; else hst_wr_n = 1'b0;
  endtask

  task automatic host_release();
    @(negedge clk);
    hst_cs_n = 2'b11; hst_a0 = 1'b1; hst_rd_n = 1'b1; hst_wr_n = 1'b1;
    repeat (HOST_LAT + 1) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic host_op(input logic rd, input logic [1:0] ch, input logic a0);
    host_drive(rd, ch, a0);
    repeat (HOST_LAT) @(posedge clk);
    host_release();
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; slave_mode = 1'b1;
    sl_sel = 1'b0; sl_wr = 1'b0; sl_addr = '0; sl_wdata = '0;
    hst_cs_n = 2'b11; hst_a0 = 1'b1; hst_rd_n = 1'b1; hst_wr_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);

    // R1: reset state
    check(1, "host_irq after reset", {5'b0, host_irq}, 8'h00);
    check(1, "rx_irq after reset", {6'b0, rx_irq}, 8'h00);
    sl_addr = 2'd1; #1;
    check(1, "ctrl/status after reset", sl_rdata, 8'h00);

    foreach (VEC[k]) begin
      logic [1:0] op, a; logic [7:0] d; logic a0; logic [2:0] eh; logic [1:0] er; logic [3:0] rq;
      {op, a, d, a0, eh, er, rq} = VEC[k];
      case (op)
        OP_SWR: slave_op(1'b1, a, d);
        OP_SRD: slave_op(1'b0, a, d);
        OP_HRD: host_op(1'b1, a, a0);
        default: host_op(1'b0, a, a0);
      endcase
      check(int'(rq), $sformatf("vec %0d host_irq", k), {5'b0, host_irq}, {5'b0, eh});
      check(int'(rq), $sformatf("vec %0d rx_irq", k), {6'b0, rx_irq}, {6'b0, er});
    end

    // R3: status readback of full flags (ch1 full, enables 11)
    host_op(1'b0, 2'd1, 1'b0);
    sl_addr = 2'd1; #1;
    check(3, "status readback", sl_rdata, 8'h07);
    slave_op(1'b0, 2'd2, 8'h00);

    // R12: host write latency, one edge early then on time
    host_drive(1'b0, 2'd2, 1'b0);
    repeat (HOST_LAT - 1) @(posedge clk);
    @(negedge clk);
    check(12, "rx_irq one edge early", {6'b0, rx_irq}, 8'h00);
    @(posedge clk);
    @(negedge clk);
    check(12, "rx_irq on time", {6'b0, rx_irq}, 8'h02);
    host_release();
    slave_op(1'b0, 2'd3, 8'h00);
    check(12, "slave read clears after one edge", {6'b0, rx_irq}, 8'h00);

    // R8: read strobe held low clears once only
    slave_op(1'b0, 2'd0, 8'h00);
    slave_op(1'b1, 2'd0, 8'h38);
    host_drive(1'b1, 2'd1, 1'b0);
    repeat (HOST_LAT) @(posedge clk);
    @(negedge clk);
    check(8, "first clear", {5'b0, host_irq}, 8'h01);
    slave_op(1'b0, 2'd0, 8'h00);
    slave_op(1'b1, 2'd0, 8'h38);
    repeat (6) @(posedge clk);
    @(negedge clk);
    check(8, "set while strobe held", {5'b0, host_irq}, 8'h07);
    host_release();
    check(8, "after release", {5'b0, host_irq}, 8'h07);
    slave_op(1'b1, 2'd0, 8'h00);

    // R10: host clear and slave set in the same cycle
    slave_op(1'b0, 2'd0, 8'h00);
    host_drive(1'b1, 2'd1, 1'b0);
    repeat (SYNC_STAGES) @(posedge clk);
    @(negedge clk);
    sl_sel = 1'b1; sl_wr = 1'b1; sl_addr = 2'd0; sl_wdata = 8'h38;
    @(posedge clk);
    @(negedge clk);
    sl_sel = 1'b0; sl_wr = 1'b0;
    check(10, "clear wins", {5'b0, host_irq}, 8'h01);
    host_release();
    slave_op(1'b1, 2'd0, 8'h00);

    // R11: slave mode off
    slave_mode = 1'b0;
    slave_op(1'b0, 2'd0, 8'h00);
    slave_op(1'b1, 2'd0, 8'h38);
    check(11, "mode off output", {5'b0, host_irq}, 8'h00);
    @(negedge clk) slave_mode = 1'b1;
    #1;
    check(11, "no set while mode off", {5'b0, host_irq}, 8'h00);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule